// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block is a hardware master for a three-wire serial configuration EEPROM. It drives chip select, a shift clock and the serial data line into the memory, and it samples the serial data line coming back. A client asks for one 16-bit word by pulsing a request with a word address and a width select. The block then issues a read frame on the wires and returns the word in `rdata` with a one-cycle `done` pulse.

A read frame is a start bit and a two-bit read opcode, then a 6-bit or 8-bit word address, then sixteen data clocks. The length of every phase of the shift clock is a run-time number of system clock cycles, so the wire rate can be kept under the memory's limit. In auto-width mode the block does not know the address width in advance. It first reads word 0 with an 8-bit address, picks 8 bits if that word equals a fixed signature and 6 bits otherwise, and then reads the requested word with the chosen width.

Top module: `seeprom_reader`

## Requirements
- R1: After reset, `ee_cs`, `ee_sk`, `ee_di`, `busy` and `done` are all 0.
- R2: Each frame sends, MSB first on `ee_di` at `ee_sk` rising edges, the bits 1,1,0 and then the address. `width_sel` 2'b00 selects a 6-bit address (`addr[5:0]`, 9 command bits). 2'b01 selects an 8-bit address (11 command bits).
- R3: A frame starts with one phase of `ee_cs` low after the request. `ee_cs` is then high for the command and data clocks, giving exactly command-bits + 16 rising edges of `ee_sk`. It falls one phase before `done` while `busy` is still high.
- R4: `ee_di` changes only while `ee_sk` is low. It is held stable through every high phase.
- R5: Sixteen data bits are sampled from `ee_do` while `ee_sk` is high, MSB first, and `rdata` holds the addressed word when `done` is high.
- R6: Every phase lasts max(1, `half_period`) system cycles, with `half_period` captured at the accepted request. A frame takes 2*N+36 phases, where N is the number of command bits.
- R7: `done` is a single-cycle pulse, and `busy` is already low in that cycle.
- R8: A request while `busy` is high is ignored. No extra frame is sent and the result belongs to the first request.
- R9: `width_sel` 2'b10 or 2'b11 selects auto width. Word 0 is first read with an 8-bit address. If it equals 16'h8129 the requested word is read with 8 address bits, otherwise with 6. `done` is raised only after the second frame.
- R10: While `ee_cs` is low, `ee_sk` is low, and while idle `ee_di` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_period | input | DIV_W | Phase length in system cycles (0 means 1) |
| req | input | 1 | Read request, accepted when idle |
| addr | input | ADDR_LONG | Word address |
| width_sel | input | 2 | 00: 6-bit, 01: 8-bit, 1x: auto width |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse, result valid |
| rdata | output | DATA_W | Word read from the memory |
| ee_cs | output | 1 | Memory chip select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial data into the memory |
| ee_do | input | 1 | Serial data out of the memory |

## Verification
An off-by-one in the bit counter changes the number of `ee_sk` rising edges in a frame. This shows when `ee_cs` falls, and a memory model then returns a word shifted by a bit, which is seen at the next `done`. A wrong phase timer appears at the first falling edge of `ee_sk`, as a high phase of the wrong length. A wrong probe decision in auto mode appears as a second frame of the wrong length and a wrong word, one frame later. A request that slips through while busy appears as an extra chip-select frame and a changed result.

// File: rtl/seeprom_pkg.sv
// Shared types and constants for the serial EEPROM word reader.
// Assumes a three-wire memory whose read command is start bit plus opcode.
package seeprom_pkg;

    // Start bit followed by the two-bit read opcode, sent first.
    localparam logic [2:0] RD_OPCODE = 3'b110;

    // Phases of one frame; each lasts one divider period.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PRE,     // chip select low, memory port enabled
        PH_CSUP,    // chip select raised, clock low
        PH_CMD_LO,  // command bit presented, clock low
        PH_CMD_HI,  // command bit held, clock high
        PH_GAP,     // clock low between command and data
        PH_DAT_HI,  // clock high, data sampled at phase end
        PH_DAT_LO,  // clock low after a data bit
        PH_END      // chip select dropped
    } phase_e;

endpackage

// File: rtl/seeprom_divider.sv
// Phase timer: pulses tick at the last system cycle of each phase.
// Assumes the phase length is captured once per accepted request.
module seeprom_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tick
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] lim_q;
    logic [DIV_W-1:0] cnt_q;

    // Capture the phase length at the start of an access, zero maps to one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= ONE;
        else if (start)
            lim_q <= (half_period == '0) ? ONE : half_period;
    end

    // Count system cycles inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + ONE;
    end

    assign tick = run && (cnt_q == (lim_q - ONE));

endmodule

// File: rtl/seeprom_shifter.sv
// Command serializer and data deserializer for one read frame.
// Assumes a short address is left-aligned so the MSB leaves first.
module seeprom_shifter
    import seeprom_pkg::*;
#(
    parameter int ADDR_LONG  = 8,
    parameter int ADDR_SHORT = 6,
    parameter int DATA_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 wide,
    input  logic [ADDR_LONG-1:0] load_addr,
    input  logic                 shift,
    input  logic                 sample,
    input  logic                 din,
    output logic                 cmd_msb,
    output logic [DATA_W-1:0]    word
);
    localparam int CMD_W = 3 + ADDR_LONG;
    localparam int PAD_W = ADDR_LONG - ADDR_SHORT;

    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] word_q;

    // Load the read command, then move it out one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (load)
            cmd_q <= wide ? {RD_OPCODE, load_addr}
                          : {RD_OPCODE, load_addr[ADDR_SHORT-1:0], {PAD_W{1'b0}}};
        else if (shift)
            cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
    end

    // Collect returned data bits, first bit ends up as the MSB.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (sample)
            word_q <= {word_q[DATA_W-2:0], din};
    end

    assign cmd_msb = cmd_q[CMD_W-1];
    assign word    = word_q;

endmodule

// File: rtl/seeprom_ctrl.sv
// Frame sequencer: walks the phases of a read, counts bits, runs the
// optional width probe and raises done. Wire levels are decoded from
// registered state only. Assumes tick marks the end of each phase.
module seeprom_ctrl
    import seeprom_pkg::*;
#(
    parameter int              ADDR_LONG  = 8,
    parameter int              ADDR_SHORT = 6,
    parameter int              DATA_W     = 16,
    parameter logic [DATA_W-1:0] PROBE_WORD = 16'h8129
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 req,
    input  logic [ADDR_LONG-1:0] addr,
    input  logic [1:0]           width_sel,
    input  logic                 cmd_msb,
    input  logic [DATA_W-1:0]    word,
    output logic                 load,
    output logic                 wide,
    output logic [ADDR_LONG-1:0] load_addr,
    output logic                 shift,
    output logic                 sample,
    output logic                 busy,
    output logic                 done,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di
);
    localparam int CMD_W = 3 + ADDR_LONG;
    localparam int MAX_BITS = (CMD_W > DATA_W) ? CMD_W : DATA_W;
    localparam int BIT_W = $clog2(MAX_BITS);
    localparam logic [BIT_W-1:0] CMD_LAST_L = BIT_W'(CMD_W - 1);
    localparam logic [BIT_W-1:0] CMD_LAST_S = BIT_W'(CMD_W - 1 - (ADDR_LONG - ADDR_SHORT));
    localparam logic [BIT_W-1:0] DAT_LAST   = BIT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] BIT_ONE    = BIT_W'(1);

    phase_e               ph_q, ph_d;
    logic [BIT_W-1:0]     bit_q, bit_d;
    logic                 probe_q, probe_d;
    logic                 wide_q;
    logic [ADDR_LONG-1:0] user_addr_q;
    logic                 done_q;
    logic                 finish;
    logic [BIT_W-1:0]     cmd_last;

    assign cmd_last = wide_q ? CMD_LAST_L : CMD_LAST_S;

    // Next phase, bit count and datapath strobes.
    always_comb begin
        ph_d      = ph_q;
        bit_d     = bit_q;
        probe_d   = probe_q;
        load      = 1'b0;
        wide      = wide_q;
        load_addr = user_addr_q;
        shift     = 1'b0;
        sample    = 1'b0;
        finish    = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    ph_d = PH_PRE;
                    if (width_sel[1]) begin
                        probe_d   = 1'b1;
                        wide      = 1'b1;
                        load_addr = '0;
                    end else begin
                        probe_d   = 1'b0;
                        wide      = width_sel[0];
                        load_addr = addr;
                    end
                end
            end
            PH_PRE:    if (tick) ph_d = PH_CSUP;
            PH_CSUP: begin
                if (tick) begin
                    ph_d  = PH_CMD_LO;
                    bit_d = '0;
                end
            end
            PH_CMD_LO: if (tick) ph_d = PH_CMD_HI;
            PH_CMD_HI: begin
                if (tick) begin
                    shift = 1'b1;
                    if (bit_q == cmd_last) begin
                        ph_d = PH_GAP;
                    end else begin
                        bit_d = bit_q + BIT_ONE;
                        ph_d  = PH_CMD_LO;
                    end
                end
            end
            PH_GAP: begin
                if (tick) begin
                    ph_d  = PH_DAT_HI;
                    bit_d = '0;
                end
            end
            PH_DAT_HI: begin
                if (tick) begin
                    sample = 1'b1;
                    ph_d   = PH_DAT_LO;
                end
            end
            PH_DAT_LO: begin
                if (tick) begin
                    if (bit_q == DAT_LAST) begin
                        ph_d = PH_END;
                    end else begin
                        bit_d = bit_q + BIT_ONE;
                        ph_d  = PH_DAT_HI;
                    end
                end
            end
            PH_END: begin
                if (tick) begin
                    if (probe_q) begin
                        load    = 1'b1;
                        probe_d = 1'b0;
                        wide    = (word == PROBE_WORD);
                        ph_d    = PH_PRE;
                    end else begin
                        finish = 1'b1;
                        ph_d   = PH_IDLE;
                    end
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // Sequencer state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= PH_IDLE;
            bit_q   <= '0;
            probe_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            ph_q    <= ph_d;
            bit_q   <= bit_d;
            probe_q <= probe_d;
            done_q  <= finish;
        end
    end

    // Remember the width in use and the client's address for the probe path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q      <= 1'b0;
            user_addr_q <= '0;
        end else begin
            if (load)
                wide_q <= wide;
            if (ph_q == PH_IDLE && req)
                user_addr_q <= addr;
        end
    end

    assign busy  = (ph_q != PH_IDLE);
    assign done  = done_q;
    assign ee_cs = (ph_q == PH_CSUP)   || (ph_q == PH_CMD_LO) || (ph_q == PH_CMD_HI) ||
                   (ph_q == PH_GAP)    || (ph_q == PH_DAT_HI) || (ph_q == PH_DAT_LO);
    assign ee_sk = (ph_q == PH_CMD_HI) || (ph_q == PH_DAT_HI);
    assign ee_di = ((ph_q == PH_CMD_LO) || (ph_q == PH_CMD_HI)) && cmd_msb;

endmodule

// File: rtl/seeprom_reader.sv
// Top of the serial EEPROM word reader: phase timer, shifter, sequencer.
// Assumes half_period is steady while an access is accepted.
module seeprom_reader #(
    parameter int                ADDR_LONG  = 8,
    parameter int                ADDR_SHORT = 6,
    parameter int                DATA_W     = 16,
    parameter int                DIV_W      = 8,
    parameter logic [DATA_W-1:0] PROBE_WORD = 16'h8129
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     half_period,
    input  logic                 req,
    input  logic [ADDR_LONG-1:0] addr,
    input  logic [1:0]           width_sel,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    input  logic                 ee_do
);
    logic                 tick;
    logic                 start;
    logic                 load;
    logic                 wide;
    logic [ADDR_LONG-1:0] load_addr;
    logic                 shift;
    logic                 sample;
    logic                 cmd_msb;
    logic [DATA_W-1:0]    word;

    // An access is accepted only from idle.
    assign start = req && !busy;

    seeprom_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .run         (busy),
        .half_period (half_period),
        .tick        (tick)
    );

    seeprom_shifter #(
        .ADDR_LONG  (ADDR_LONG),
        .ADDR_SHORT (ADDR_SHORT),
        .DATA_W     (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wide      (wide),
        .load_addr (load_addr),
        .shift     (shift),
        .sample    (sample),
        .din       (ee_do),
        .cmd_msb   (cmd_msb),
        .word      (word)
    );

    seeprom_ctrl #(
        .ADDR_LONG  (ADDR_LONG),
        .ADDR_SHORT (ADDR_SHORT),
        .DATA_W     (DATA_W),
        .PROBE_WORD (PROBE_WORD)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .req       (req),
        .addr      (addr),
        .width_sel (width_sel),
        .cmd_msb   (cmd_msb),
        .word      (word),
        .load      (load),
        .wide      (wide),
        .load_addr (load_addr),
        .shift     (shift),
        .sample    (sample),
        .busy      (busy),
        .done      (done),
        .ee_cs     (ee_cs),
        .ee_sk     (ee_sk),
        .ee_di     (ee_di)
    );

    assign rdata = word;

endmodule

// File: rtl/seeprom_reader_chk.sv
// Protocol checker for the serial EEPROM word reader, bound to the top.
// Assumes only port-level signals; keeps its own phase-length counter.
module seeprom_reader_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] half_period,
    input logic             req,
    input logic             busy,
    input logic             done,
    input logic             ee_cs,
    input logic             ee_sk,
    input logic             ee_di
);
    logic [DIV_W:0] lim_q;
    logic [DIV_W:0] hi_cnt;

    // Expected phase length, captured when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lim_q <= (DIV_W+1)'(1);
        else if (req && !busy)
            lim_q <= (half_period == '0) ? (DIV_W+1)'(1) : {1'b0, half_period};
    end

    // Length of the current high phase of the shift clock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (ee_sk)
            hi_cnt <= hi_cnt + (DIV_W+1)'(1);
        else
            hi_cnt <= '0;
    end

    // R6: each high phase lasts the captured phase length
    assert_hi_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_sk && $past(ee_sk)) |-> (hi_cnt == lim_q));

    // R4: data line held through a high phase
    assert_di_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

    // R10: no clock without chip select
    assert_sk_framed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    // R10: quiet wires while idle
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!ee_cs && !ee_di));

    // R7: done only with busy already low
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7: done lasts one cycle
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an access only begins from a request
    assert_start_on_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    // R3: chip select drops before the access ends
    assert_cs_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |-> busy);

endmodule

bind seeprom_reader seeprom_reader_chk #(.DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .half_period (half_period),
    .req         (req),
    .busy        (busy),
    .done        (done),
    .ee_cs       (ee_cs),
    .ee_sk       (ee_sk),
    .ee_di       (ee_di)
);

// File: tb/seeprom_reader_bench.sv
module seeprom_reader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  half_period = 8'd0;
    logic        req = 1'b0;
    logic [7:0]  addr = 8'd0;
    logic [1:0]  width_sel = 2'b00;
    logic        busy, done;
    logic [15:0] rdata;
    logic        ee_cs, ee_sk, ee_di;
    logic        ee_do = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    seeprom_reader u_seeprom_reader (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .req(req),
        .addr(addr), .width_sel(width_sel), .busy(busy), .done(done),
        .rdata(rdata), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    int n_checks = 0;
    int n_err = 0;

    // Memory model settings, written only by the stimulus.
    logic        mdl_w8 = 1'b0;
    logic [15:0] word0 = 16'h1234;
    int          exp_lim = 1;

    function automatic logic [15:0] mem_word(input logic [7:0] a);
        return (a == 8'h00) ? word0 : {a ^ 8'hA5, ~a};
    endfunction

    // Memory model: one process reacts to chip select and clock edges.
    logic        cs_prev = 1'b0;
    int          rises = 0;
    logic [10:0] cmd_sh = '0;
    logic [15:0] dev_word = '0;
    int          sess = 0;
    int          last_rises = 0, prev_rises = 0;
    logic [10:0] last_cmd = '0, prev_cmd = '0;

    always @(edge ee_cs or posedge ee_sk) begin
        if (ee_cs !== cs_prev) begin
            if (ee_cs) begin
                rises  = 0;
                cmd_sh = '0;
            end else begin
                prev_cmd   = last_cmd;
                prev_rises = last_rises;
                last_cmd   = cmd_sh;
                last_rises = rises;
                sess       = sess + 1;
            end
            cs_prev = ee_cs;
            ee_do   = 1'b0;
        end else if (ee_sk && ee_cs) begin
            int dl;
            dl    = mdl_w8 ? 11 : 9;
            rises = rises + 1;
            if (rises <= 11) cmd_sh = {cmd_sh[9:0], ee_di};
            if (rises == dl)
                dev_word = mem_word(mdl_w8 ? cmd_sh[7:0] : {2'b00, cmd_sh[5:0]});
            if (rises > dl && rises <= dl + 16)
                ee_do = dev_word[dl + 16 - rises];
            else
                ee_do = 1'b0;
        end
    end

    // Wire monitor: high-phase lengths and framing violations.
    int hi_run = 0, hi_bad = 0, viol = 0;
    always @(posedge clk) begin
        if (ee_sk) hi_run = hi_run + 1;
        else if (hi_run != 0) begin
            if (hi_run != exp_lim) hi_bad = hi_bad + 1;
            hi_run = 0;
        end
        if (rst_n && !ee_cs && (ee_sk || ee_di)) viol = viol + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    int          got_k, cs_rise_k, cs_fall_k;
    logic [15:0] got_word;

    task automatic do_read(input logic [1:0] ws, input logic [7:0] a,
                           input logic [7:0] hp, input bit inject);
        int k;
        bit ok;
        @(negedge clk);
        half_period = hp; addr = a; width_sel = ws; req = 1'b1;
        exp_lim = (hp == 0) ? 1 : int'(hp);
        @(posedge clk); #2;
        req = 1'b0;
        k = 0; ok = 0; cs_rise_k = -1; cs_fall_k = -1; got_k = -1;
        while (k < 6000 && !ok) begin
            @(posedge clk); #2;
            k++;
            if (inject && k == 5) begin req = 1'b1; addr = 8'h33; end
            if (inject && k == 6) req = 1'b0;
            if (ee_cs && cs_rise_k < 0) cs_rise_k = k;
            if (!ee_cs && cs_rise_k >= 0 && cs_fall_k < 0) cs_fall_k = k;
            if (done) begin got_k = k; got_word = rdata; ok = 1; end
        end
        if (!ok) begin
            n_checks++; n_err++;
            $display("FAIL R7 done never seen: actual none expected pulse");
        end
        @(posedge clk); #2;
        chk("R7 done drops after one cycle", {31'd0, done}, 32'd0);
        chk("R7 idle after done", {31'd0, busy}, 32'd0);
    endtask

    // {width_sel, addr, half_period}
    localparam logic [17:0] VEC [6] = '{
        {2'b00, 8'h15, 8'd0},
        {2'b01, 8'hA7, 8'd1},
        {2'b00, 8'hC5, 8'd1},
        {2'b01, 8'hFF, 8'd3},
        {2'b00, 8'h3F, 8'd2},
        {2'b01, 8'h5E, 8'd0}
    };

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset cs", {31'd0, ee_cs}, 32'd0);
        chk("R1 reset sk", {31'd0, ee_sk}, 32'd0);
        chk("R1 reset di", {31'd0, ee_di}, 32'd0);
        chk("R1 reset busy", {31'd0, busy}, 32'd0);
        chk("R1 reset done", {31'd0, done}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(posedge clk);

        for (int i = 0; i < 6; i++) begin
            logic [1:0]  ws;
            logic [7:0]  a, hp;
            logic        w8;
            int          lim, ncmd, ph, s0, hb0;
            logic [10:0] ecmd;
            {ws, a, hp} = VEC[i];
            w8   = ws[0];
            mdl_w8 = w8;
            lim  = (hp == 0) ? 1 : int'(hp);
            ncmd = w8 ? 11 : 9;
            ph   = 2 * ncmd + 36;
            ecmd = w8 ? {3'b110, a} : {3'b110, a[5:0], 2'b00};
            s0 = sess; hb0 = hi_bad;
            do_read(ws, a, hp, 1'b0);
            chk("R2 command bits", {21'd0, last_cmd}, {21'd0, ecmd});
            chk("R3 rising edges per frame", last_rises, ncmd + 16);
            chk("R3 one frame", sess - s0, 1);
            chk("R3 cs rises after one phase", cs_rise_k, lim);
            chk("R3 cs falls one phase before done", cs_fall_k, (ph - 1) * lim);
            chk("R5 word read", {16'd0, got_word}, {16'd0, mem_word(w8 ? a : {2'b00, a[5:0]})});
            chk("R6 frame latency", got_k, ph * lim);
            chk("R4 R6 high phase length", hi_bad - hb0, 0);
        end

        // R8: second request during an access is ignored
        begin
            int s0;
            mdl_w8 = 1'b1; s0 = sess;
            do_read(2'b01, 8'h6B, 8'd1, 1'b1);
            chk("R8 single frame under extra request", sess - s0, 1);
            chk("R8 result of first request", {16'd0, got_word}, {16'd0, mem_word(8'h6B)});
            repeat (4) @(posedge clk); #2;
            chk("R8 no late start", {31'd0, busy}, 32'd0);
        end

        // R9: auto width, 8-bit memory with signature
        begin
            int s0;
            mdl_w8 = 1'b1; word0 = 16'h8129; s0 = sess;
            do_read(2'b10, 8'h9C, 8'd1, 1'b0);
            chk("R9 two frames", sess - s0, 2);
            chk("R9 probe command", {21'd0, prev_cmd}, {21'd0, 11'b110_0000_0000});
            chk("R9 probe length", prev_rises, 27);
            chk("R9 wide second command", {21'd0, last_cmd}, {21'd0, 3'b110, 8'h9C});
            chk("R9 wide word", {16'd0, got_word}, {16'd0, mem_word(8'h9C)});
            chk("R9 wide latency", got_k, 116);
        end

        // R9: auto width, 6-bit memory returns a shifted probe word
        begin
            int s0;
            mdl_w8 = 1'b0; word0 = 16'h8129; s0 = sess;
            do_read(2'b11, 8'h9C, 8'd2, 1'b0);
            chk("R9 two frames narrow", sess - s0, 2);
            chk("R9 probe length narrow", prev_rises, 27);
            chk("R9 narrow second length", last_rises, 25);
            chk("R9 narrow word", {16'd0, got_word}, {16'd0, mem_word(8'h1C)});
            chk("R9 narrow latency", got_k, (58 + 54) * 2);
        end

        // R9: signature mismatch on an 8-bit memory still selects 6 bits
        begin
            mdl_w8 = 1'b1; word0 = 16'h8128;
            do_read(2'b10, 8'hE1, 8'd0, 1'b0);
            chk("R9 mismatch picks short frame", last_rises, 25);
            chk("R9 mismatch short command", {21'd0, last_cmd}, {21'd0, 3'b110, 6'h21, 2'b00});
        end

        chk("R10 no clock or data outside chip select", viol, 0);
        chk("R10 idle data low", {31'd0, ee_di}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule